// File: doc/BRIEF.md
# Peripheral Access Gate

This block sits on the request path between one bus master and a group of memory and peripheral windows. Every request address is compared against a fixed map of equal-sized windows. If the address falls in a window that is currently switched on, the request goes on unchanged to the downstream bus. If the address falls in a window that software has switched off, or in no window at all, the request is stopped at the gate. A stopped request gets an error response and raises a one-cycle fault signal, which the system can turn into an exception.

The switches are a small register that holds one disable bit per window. The register sits at its own fixed address, and that address can never be switched off. Software can therefore always turn a window back on by clearing its bit, and needs to do nothing else.

The map is set by parameters. There are `NREG` windows of `2**RSH` addresses each, placed back to back from address 0. The disable register sits at the single address `NREG << RSH`. Every address above it is unmapped.

Top module: `periph_gate`

## Requirements
- R1: After reset every disable bit is 0, so all windows are open. No response and no fault is signalled until the first request, and a read of the disable register returns 0.
- R2: A request to an open window is passed on in the same cycle, with the same address, direction and write data. Its response follows one cycle later without error, and carries the downstream read data for reads.
- R3: A request to window i while disable bit i (bit i of the register) is 1 is not passed on. Its response carries the error flag, with read data equal to 0.
- R4: A request to an address of `NREG << RSH` plus 1 or above is not passed on. Its response carries the error flag, with read data equal to 0.
- R5: A blocked write changes no state. The target window's contents and the disable register keep their values.
- R6: Clearing a disable bit makes the window reachable again on the next request, with no other action.
- R7: The fault output is high for exactly the one cycle in which a blocked request's error response is presented. It is low in every other cycle.
- R8: The disable register, at address `NREG << RSH`, is never blocked. A write loads the bits from write data bits [NREG-1:0]. A read returns those bits zero-extended, and the response has no error. The register is never passed downstream.
- R9: Every request gets exactly one response, presented in the cycle after its address phase. No response appears in a cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request valid (address phase) |
| m_we | input | 1 | Master write enable |
| m_addr | input | AW | Master address |
| m_wdata | input | DW | Master write data |
| m_rsp_valid | output | 1 | Response valid, one cycle after the request |
| m_rsp_err | output | 1 | Response is a bus error |
| m_rdata | output | DW | Response read data (0 on error) |
| fault | output | 1 | One-cycle pulse per blocked request |
| s_req | output | 1 | Downstream request valid |
| s_we | output | 1 | Downstream write enable |
| s_addr | output | AW | Downstream address |
| s_wdata | output | DW | Downstream write data |
| s_rdata | input | DW | Downstream read data, valid the cycle after a read request |

## Verification
The assertions assume that `m_req` is never unknown after reset. They also assume that the downstream side returns read data exactly one cycle after it sees a read request. The bench's downstream model is a single-cycle memory, so it meets that rule by construction. Requests are driven on the falling edge, either one at a time or with idle cycles between them. Each response and each fault sample is therefore tied to exactly one request.

// File: rtl/pg_pkg.sv
package pg_pkg;

  // Source of the data returned in the response cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DOWN = 2'd1,
    SRC_CFG  = 2'd2,
    SRC_ERR  = 2'd3
  } src_e;

  // Window number an address falls into (windows are 2**rsh wide)
  function automatic int unsigned win_index(input logic [31:0] addr, input int unsigned rsh);
    return int'(addr >> rsh);
  endfunction

  // Address of the disable register: first word after the last window
  function automatic int unsigned ctl_addr(input int unsigned nreg, input int unsigned rsh);
    return nreg << rsh;
  endfunction

endpackage

// File: rtl/pg_decode.sv
module pg_decode #(
  parameter int unsigned AW   = 12,
  parameter int unsigned NREG = 4,
  parameter int unsigned RSH  = 8
) (
  input  logic [AW-1:0]   addr,
  input  logic [NREG-1:0] dis,
  output logic [NREG-1:0] hit_win,
  output logic            hit_ctl,
  output logic            blocked
);
  localparam int unsigned CTL_A = pg_pkg::ctl_addr(NREG, RSH);

  logic [AW-1:0] win_no;
  assign win_no = addr >> RSH;

  for (genvar i = 0; i < NREG; i++) begin : g_win
    assign hit_win[i] = (win_no == AW'(i));
  end

  assign hit_ctl = (addr == AW'(CTL_A));
  assign blocked = !(hit_ctl || (|(hit_win & ~dis)));
endmodule

// File: rtl/pg_cfg.sv
module pg_cfg #(
  parameter int unsigned NREG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NREG-1:0] wr_bits,
  output logic [NREG-1:0] dis_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dis_q <= '0;
    else if (wr_en) dis_q <= wr_bits;
  end
endmodule

// File: rtl/pg_resp.sv
module pg_resp #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            blocked,
  input  logic            hit_ctl,
  input  logic [NREG-1:0] dis_q,
  input  logic [DW-1:0]   down_rdata,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [DW-1:0]   rdata,
  output logic            fault
);
  import pg_pkg::*;

  src_e            src_q;
  logic [NREG-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_NONE;
      snap_q <= '0;
    end else begin
      if (!req)         src_q <= SRC_NONE;
      else if (blocked) src_q <= SRC_ERR;
      else if (hit_ctl) src_q <= SRC_CFG;
      else              src_q <= SRC_DOWN;
      if (req && hit_ctl) snap_q <= dis_q;
    end
  end

  assign rsp_valid = (src_q != SRC_NONE);
  assign rsp_err   = (src_q == SRC_ERR);
  assign fault     = rsp_err;

  always_comb begin
    case (src_q)
      SRC_DOWN: rdata = down_rdata;
      SRC_CFG:  rdata = {{(DW-NREG){1'b0}}, snap_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/periph_gate.sv
module periph_gate #(
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4,
  parameter int unsigned RSH  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  output logic          m_rsp_valid,
  output logic          m_rsp_err,
  output logic [DW-1:0] m_rdata,
  output logic          fault,
  output logic          s_req,
  output logic          s_we,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata,
  input  logic [DW-1:0] s_rdata
);
  logic [NREG-1:0] hit_win;
  logic            hit_ctl;
  logic            blocked;
  logic [NREG-1:0] dis_q;
  logic            ctl_wr;

  pg_decode #(.AW(AW), .NREG(NREG), .RSH(RSH)) u_dec (
    .addr(m_addr), .dis(dis_q), .hit_win(hit_win), .hit_ctl(hit_ctl), .blocked(blocked)
  );

  assign ctl_wr = m_req && m_we && hit_ctl;

  pg_cfg #(.NREG(NREG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_bits(m_wdata[NREG-1:0]), .dis_q(dis_q)
  );

  assign s_req   = m_req && !blocked && !hit_ctl;
  assign s_we    = m_we;
  assign s_addr  = m_addr;
  assign s_wdata = m_wdata;

  pg_resp #(.DW(DW), .NREG(NREG)) u_rsp (
    .clk(clk), .rst_n(rst_n), .req(m_req), .blocked(blocked), .hit_ctl(hit_ctl),
    .dis_q(dis_q), .down_rdata(s_rdata), .rsp_valid(m_rsp_valid), .rsp_err(m_rsp_err),
    .rdata(m_rdata), .fault(fault)
  );
endmodule

// File: rtl/pg_chk.sv
module pg_chk #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            m_req,
  input logic            m_we,
  input logic            hit_ctl,
  input logic            blocked,
  input logic            s_req,
  input logic            m_rsp_valid,
  input logic            m_rsp_err,
  input logic [DW-1:0]   m_rdata,
  input logic            fault,
  input logic [NREG-1:0] dis_q
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |=> m_rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !m_req |=> !m_rsp_valid); // R9
  AST_BLOCK_ERRS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && blocked) |=> (m_rsp_err && fault)); // R3
  AST_FWD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    s_req |=> (m_rsp_valid && !m_rsp_err)); // R2
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_err |-> (m_rdata == '0)); // R3
  AST_FAULT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (m_rsp_valid && m_rsp_err)); // R7
  AST_FAULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !m_req |=> !fault); // R7
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_req && m_we && hit_ctl) |=> $stable(dis_q)); // R5
endmodule

bind periph_gate pg_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .hit_ctl(hit_ctl),
  .blocked(blocked), .s_req(s_req), .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err),
  .m_rdata(m_rdata), .fault(fault), .dis_q(dis_q)
);

// File: tb/periph_gate_tb.sv
module periph_gate_tb;
  localparam int AW = 12, DW = 16, NREG = 4, RSH = 8;
  localparam int CTL = NREG << RSH;
  localparam int MW  = NREG << RSH;

  logic clk = 0, rst_n = 0;
  logic m_req = 0, m_we = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic m_rsp_valid, m_rsp_err, fault, s_req, s_we;
  logic [DW-1:0] m_rdata, s_wdata;
  logic [DW-1:0] s_rdata = '0;
  logic [AW-1:0] s_addr;

  int total = 0, bad = 0;
  logic [DW-1:0] mem [MW];
  logic [DW-1:0] sh  [MW];
  logic [NREG-1:0] cur_mask = '0;

  always #2 clk = ~clk;

  periph_gate #(.AW(AW), .DW(DW), .NREG(NREG), .RSH(RSH)) u_dut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err),
    .m_rdata(m_rdata), .fault(fault), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  // Downstream: single-cycle memory
  always @(posedge clk) begin
    if (s_req) begin
      if (s_we) mem[s_addr[9:0]] <= s_wdata;
      else      s_rdata <= mem[s_addr[9:0]];
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // One request, then one idle cycle; all expectations computed here
  task automatic acc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     output logic [DW-1:0] rd);
    int  w;
    bit  is_ctl, is_win, blk;
    logic fwd;
    logic [DW-1:0] exp_rd;
    logic [3:0] got, exp;
    w      = int'(a) >> RSH;
    is_ctl = (int'(a) == CTL);
    is_win = (w < NREG);
    blk    = !is_ctl && !(is_win && !cur_mask[w]);
    @(negedge clk);
    m_req = 1; m_we = we; m_addr = a; m_wdata = wd;
    #1 fwd = s_req;
    @(negedge clk);
    m_req = 0; m_we = 0;
    rd  = m_rdata;
    got = {m_rsp_valid, m_rsp_err, fault, fwd};
    exp = {1'b1, blk, blk, !blk && !is_ctl};
    if (blk) begin
      check(got == exp, is_win ? "R3 disabled window" : "R4 unmapped", got, exp);
      check(rd == '0, is_win ? "R3 error data" : "R4 error data", rd, 0);
      check(fault, "R7 fault on block", fault, 1);
    end else if (is_ctl) begin
      check(got == exp, "R8 ctl access", got, exp);
      if (!we) check(rd == DW'(cur_mask), "R8 ctl read", rd, cur_mask);
    end else begin
      exp_rd = sh[a[9:0]];
      check(got == exp, "R2 forward", got, exp);
      if (!we) check(rd == exp_rd, "R2 read data", rd, exp_rd);
    end
    if (!blk && is_ctl && we) cur_mask = wd[NREG-1:0];
    if (!blk && !is_ctl && we) sh[a[9:0]] = wd;
    @(negedge clk);
    check(!m_rsp_valid && !fault, "R9 R7 idle after rsp", {m_rsp_valid, fault}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    for (int i = 0; i < MW; i++) begin
      mem[i] = DW'(i * 7 + 3);
      sh[i]  = DW'(i * 7 + 3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!m_rsp_valid && !fault, "R1 reset outputs", {m_rsp_valid, fault}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!m_rsp_valid && !fault, "R1 idle after reset", {m_rsp_valid, fault}, 0);
    acc(0, AW'(CTL), '0, rd);
    check(rd == '0, "R1 disable bits clear", rd, 0);

    // Sweep every address with all windows open
    for (int a = 0; a < (1 << AW); a++) acc(0, AW'(a), '0, rd);

    // Every disable mask: write, read back, try reads and writes in each window
    for (int m = 0; m < (1 << NREG); m++) begin
      acc(1, AW'(CTL), DW'(m) | 16'hF0, rd);
      acc(0, AW'(CTL), '0, rd);
      check(rd == DW'(m), "R8 mask readback", rd, m);
      for (int w = 0; w < NREG; w++) begin
        logic [AW-1:0] a;
        a = AW'((w << RSH) + m * 5 + w);
        acc(0, a, '0, rd);
        acc(1, a, DW'(16'hA000 + m * 16 + w), rd);
        acc(0, AW'(CTL + 1 + m), '0, rd);
      end
      // Blocked writes must not have touched the disable bits
      acc(0, AW'(CTL), '0, rd);
      check(rd == DW'(m), "R5 mask unchanged", rd, m);
      // Reopen and verify contents (R5, R6)
      acc(1, AW'(CTL), '0, rd);
      for (int w = 0; w < NREG; w++) begin
        acc(0, AW'((w << RSH) + m * 5 + w), '0, rd);
        check(m_rsp_err == 0, "R6 reopened window", m_rsp_err, 0);
      end
    end

    // Back-to-back blocked requests: one fault per request
    acc(1, AW'(CTL), 16'h000F, rd);
    @(negedge clk);
    m_req = 1; m_we = 0; m_addr = 12'h010;
    @(negedge clk);
    check(fault && m_rsp_err, "R7 first blocked", fault, 1);
    m_addr = 12'hFFF;
    @(negedge clk);
    m_req = 0;
    check(fault && m_rsp_err, "R7 second blocked", fault, 1);
    @(negedge clk);
    check(!fault && !m_rsp_valid, "R7 pulse ends", fault, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule